// File: doc/BRIEF.md
# Latched Power-Down Event Interrupt Bank

This block watches a small group of power-related input lines for short level events. The events can occur while the register clock is stopped. Each channel has a capture cell that sets with no clock at all, as soon as its input shows the active level while the channel is enabled. The cell then holds that state until software clears it. A two-flop synchronizer carries the held state into the register clock domain. Software reads it there as raw status, reads it again masked by the enables, and sees the OR of the masked bits on a single interrupt line.

Each channel's active level comes from a polarity bit. A 0 in that bit selects a high level and a 1 selects a low level. The bank triggers on levels only. Software can emulate an edge by flipping the polarity after each event and then clearing. A clear only takes effect once the input has left its active level. While the input is still active the capture cell sets again at once. A spare storage register is writable and readable but changes no behaviour.

Top module: `pdlat_bank`

## Requirements
- R1: Reset (`rst_ni` low, asynchronous) sets enable, polarity, spare and all captured state to 0. Every readable register then reads 0 and `irq_o` is 0, even if an input is active at that moment.
- R2: The enable (offset 0x00), polarity (0x10) and spare (0x14) registers store bits [CHANNELS-1:0] of a write and read them back. Bits above CHANNELS-1 are ignored on write and read as 0.
- R3: For channel i, a polarity bit of 0 makes a high input level active and a polarity bit of 1 makes a low input level active.
- R4: A channel whose enable bit is 0 never captures, whatever its input does.
- R5: An active pulse on an enabled channel is captured even when it starts and ends between two clock edges. The captured state holds until a clear.
- R6: Raw status (offset 0x04, bit i = channel i) shows a capture after the second rising clock edge that follows the set of the capture cell, and not before.
- R7: Writing to offset 0x0C clears the capture of each channel whose data bit is 1, provided its input is inactive. Bits written as 0 leave their channels unchanged.
- R8: A clear of a channel whose input is still active leaves that channel captured.
- R9: Masked status (offset 0x08) is raw status AND enable. `irq_o` is 1 exactly when masked status is nonzero. Disabling a channel hides its capture without discarding it.
- R10: Offset 0x0C and every offset not listed above read as 0. A write to an unlisted offset changes no register.
- R11: The value held in the spare register has no effect on capture, status or interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_pin_i | input | CHANNELS | Event input lines, one per channel |
| reg_sel_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | Access is a write when 1 |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt, OR of masked status |

## Verification
The bench drives pulses that rise and fall wholly within the low clock phase. A design that sampled its inputs on the clock would miss them and show no status. It also issues clears while an input is still active. A design that let the clear win over the set would drop the event. The bench samples raw status one and two edges after a capture, which exposes a synchronizer that is one stage short or one stage long. It also disables a captured channel, which reveals a design that discards captures on disable instead of only masking them. Finally, it writes to unlisted offsets and writes all ones to the spare register, so any aliasing in the decode or any leak from the spare bits into behaviour shows up as a mismatch against the model.

// File: rtl/pdlat_pkg.sv
package pdlat_pkg;

   // Byte offsets of the register window; software decodes these.
   localparam logic [7:0] OFS_ENABLE   = 8'h00;
   localparam logic [7:0] OFS_RAW      = 8'h04;
   localparam logic [7:0] OFS_MASKED   = 8'h08;
   localparam logic [7:0] OFS_CLEAR    = 8'h0C;
   localparam logic [7:0] OFS_POLARITY = 8'h10;
   localparam logic [7:0] OFS_SPARE    = 8'h14;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_ENABLE,
      RSEL_RAW,
      RSEL_MASKED,
      RSEL_CLEAR,
      RSEL_POLARITY,
      RSEL_SPARE
   } rsel_e;

   function automatic rsel_e decode_ofs(input logic [7:0] ofs);
      rsel_e r;
      case (ofs)
         OFS_ENABLE:   r = RSEL_ENABLE;
         OFS_RAW:      r = RSEL_RAW;
         OFS_MASKED:   r = RSEL_MASKED;
         OFS_CLEAR:    r = RSEL_CLEAR;
         OFS_POLARITY: r = RSEL_POLARITY;
         OFS_SPARE:    r = RSEL_SPARE;
         default:      r = RSEL_NONE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pdlat_capture.sv
// Clockless capture cells: one asynchronous-set storage element per channel.
module pdlat_capture #(
   parameter int CHANNELS = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [CHANNELS-1:0] pin_i,
   input  logic [CHANNELS-1:0] en_i,
   input  logic [CHANNELS-1:0] pol_i,
   input  logic [CHANNELS-1:0] clr_i,
   output logic [CHANNELS-1:0] set_req_o,
   output logic [CHANNELS-1:0] latch_o
);

   if (CHANNELS < 1) begin : g_bad_ch
      $error("pdlat_capture: CHANNELS must be at least 1");
   end

   for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_cell
      logic set_w;
      logic held_q;

      // R3: polarity 0 -> high active, 1 -> low active; R4: gated by enable
      assign set_w = en_i[ch] & (pin_i[ch] ^ pol_i[ch]);

      // R5/R8: set needs no clock edge and dominates a clear (R7)
      always_ff @(posedge clk_i or negedge rst_ni or posedge set_w) begin
         if (!rst_ni) begin
            held_q <= 1'b0;
         end else if (set_w) begin
            held_q <= 1'b1;
         end else if (clr_i[ch]) begin
            held_q <= 1'b0;
         end
      end

      assign set_req_o[ch] = set_w;
      assign latch_o[ch]   = held_q;
   end

endmodule

// File: rtl/pdlat_sync.sv
// Multi-stage synchronizer carrying captured state into the register clock.
module pdlat_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pdlat_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pdlat_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/pdlat_regs.sv
// Register window: enable, polarity, spare storage, clear strobe, read mux.
module pdlat_regs
   import pdlat_pkg::*;
#(
   parameter int CHANNELS = 8,
   parameter int DATA_W   = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                sel_i,
   input  logic                wr_i,
   input  logic [7:0]          ofs_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic [CHANNELS-1:0] raw_i,
   output logic [CHANNELS-1:0] en_o,
   output logic [CHANNELS-1:0] pol_o,
   output logic [CHANNELS-1:0] clr_o,
   output logic [CHANNELS-1:0] masked_o,
   output logic [DATA_W-1:0]   rdata_o
);

   if (DATA_W < CHANNELS) begin : g_bad_dw
      $error("pdlat_regs: DATA_W must cover CHANNELS");
   end

   rsel_e               rsel_w;
   logic                wen_w;
   logic [CHANNELS-1:0] wbits_w;
   logic [CHANNELS-1:0] en_q;
   logic [CHANNELS-1:0] pol_q;
   logic [CHANNELS-1:0] spare_q;

   assign rsel_w  = decode_ofs(ofs_i);
   assign wen_w   = sel_i & wr_i;
   assign wbits_w = wdata_i[CHANNELS-1:0];    // R2: upper bits dropped

   if (DATA_W > CHANNELS) begin : g_upper
      logic unused_upper;
      assign unused_upper = ^wdata_i[DATA_W-1:CHANNELS];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q    <= '0;
         pol_q   <= '0;
         spare_q <= '0;
      end else if (wen_w) begin
         case (rsel_w)
            RSEL_ENABLE:   en_q    <= wbits_w;
            RSEL_POLARITY: pol_q   <= wbits_w;
            RSEL_SPARE:    spare_q <= wbits_w;   // R11: storage only
            default: ;
         endcase
      end
   end

   // R7: one-cycle clear strobe, only the bits written as 1
   assign clr_o    = (wen_w && rsel_w == RSEL_CLEAR) ? wbits_w : '0;
   assign masked_o = raw_i & en_q;
   assign en_o     = en_q;
   assign pol_o    = pol_q;

   // R10: clear and unlisted offsets read zero
   always_comb begin
      rdata_o = '0;
      case (rsel_w)
         RSEL_ENABLE:   rdata_o = DATA_W'(en_q);
         RSEL_RAW:      rdata_o = DATA_W'(raw_i);
         RSEL_MASKED:   rdata_o = DATA_W'(masked_o);
         RSEL_POLARITY: rdata_o = DATA_W'(pol_q);
         RSEL_SPARE:    rdata_o = DATA_W'(spare_q);
         default:       rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/pdlat_bank.sv
module pdlat_bank #(
   parameter int CHANNELS    = 8,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [CHANNELS-1:0] evt_pin_i,
   input  logic                reg_sel_i,
   input  logic                reg_wr_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   output logic                irq_o
);

   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_aw
      $error("pdlat_bank: ADDR_W must be 5 to 8");
   end

   logic [7:0]          ofs_w;
   logic [CHANNELS-1:0] en_q;
   logic [CHANNELS-1:0] pol_q;
   logic [CHANNELS-1:0] clr_pulse;
   logic [CHANNELS-1:0] set_req;
   logic [CHANNELS-1:0] latch_q;
   logic [CHANNELS-1:0] raw_q;
   logic [CHANNELS-1:0] masked_w;

   assign ofs_w = 8'(reg_addr_i);

   pdlat_capture #(.CHANNELS(CHANNELS)) i_capture (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (evt_pin_i),
      .en_i      (en_q),
      .pol_i     (pol_q),
      .clr_i     (clr_pulse),
      .set_req_o (set_req),
      .latch_o   (latch_q)
   );

   pdlat_sync #(.WIDTH(CHANNELS), .STAGES(SYNC_STAGES)) i_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (latch_q),
      .sync_o  (raw_q)
   );

   pdlat_regs #(.CHANNELS(CHANNELS), .DATA_W(DATA_W)) i_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (reg_sel_i),
      .wr_i     (reg_wr_i),
      .ofs_i    (ofs_w),
      .wdata_i  (reg_wdata_i),
      .raw_i    (raw_q),
      .en_o     (en_q),
      .pol_o    (pol_q),
      .clr_o    (clr_pulse),
      .masked_o (masked_w),
      .rdata_o  (reg_rdata_o)
   );

   // R9: interrupt is the OR of masked status
   assign irq_o = |masked_w;

endmodule

// File: rtl/pdlat_bank_chk.sv
module pdlat_bank_chk #(
   parameter int CHANNELS = 8,
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 32
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [CHANNELS-1:0] latch_q,
   input logic [CHANNELS-1:0] raw_q,
   input logic [CHANNELS-1:0] en_q,
   input logic [CHANNELS-1:0] clr_pulse,
   input logic [ADDR_W-1:0]   reg_addr_i,
   input logic [DATA_W-1:0]   reg_rdata_o,
   input logic                irq_o
);

   // R4: no capture cell rises while its channel is disabled
   a_r4_no_capture_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((latch_q & ~$past(latch_q)) & ~en_q) == '0);

   // R5: a captured channel only drops after a clear strobe
   a_r5_capture_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(latch_q) & ~latch_q) & ~$past(clr_pulse)) == '0);

   // R6: raw status trails the capture cells by exactly two edges
   a_r6_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      raw_q == $past(latch_q, 2));

   // R9: no interrupt while every channel is disabled
   a_r9_irq_off_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q == '0) |-> !irq_o);

   // R10: the clear offset reads zero
   a_r10_clear_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_addr_i == ADDR_W'(12)) |-> (reg_rdata_o == '0));

endmodule

bind pdlat_bank pdlat_bank_chk #(
   .CHANNELS (CHANNELS),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W)
) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .latch_q     (latch_q),
   .raw_q       (raw_q),
   .en_q        (en_q),
   .clr_pulse   (clr_pulse),
   .reg_addr_i  (reg_addr_i),
   .reg_rdata_o (reg_rdata_o),
   .irq_o       (irq_o)
);

// File: tb/test_pdlat_bank.sv
module test_pdlat_bank;

   localparam int CLK_T = 10;
   localparam int CH    = 8;
   localparam int AW    = 5;
   localparam int DW    = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CH-1:0] pins = '0;
   logic          sel = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   // behavioural reference state
   logic [CH-1:0] lat_m = '0, raw_m = '0, en_m = '0, pol_m = '0, spare_m = '0;
   logic [CH-1:0] pipe[$];

   always #(CLK_T/2) clk = ~clk;

   pdlat_bank i_pdlat_bank (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .evt_pin_i   (pins),
      .reg_sel_i   (sel),
      .reg_wr_i    (wr),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic touch();
      if (rst_n) lat_m = lat_m | (en_m & (pins ^ pol_m));
   endtask

   function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
      case (a)
         5'h00:   return DW'(en_m);
         5'h04:   return DW'(raw_m);
         5'h08:   return DW'(raw_m & en_m);
         5'h10:   return DW'(pol_m);
         5'h14:   return DW'(spare_m);
         default: return '0;
      endcase
   endfunction

   // reference model, one step per clock
   always @(posedge clk) begin
      if (!rst_n) begin
         lat_m = '0; raw_m = '0; en_m = '0; pol_m = '0; spare_m = '0;
         pipe = '{};
         pipe.push_back('0);
      end else begin
         pipe.push_back(lat_m);
         raw_m = pipe.pop_front();
         if (sel && wr) begin
            case (addr)
               5'h00: en_m = wdata[CH-1:0];
               5'h0C: lat_m = lat_m & ~wdata[CH-1:0];
               5'h10: pol_m = wdata[CH-1:0];
               5'h14: spare_m = wdata[CH-1:0];
               default: ;
            endcase
         end
         touch();
      end
   end

   // compare against the model every cycle, a quarter period after the edge
   always @(posedge clk) begin
      #(CLK_T/4);
      if (rst_n && !done) begin
         chk("R6 per-cycle rdata", rdata, model_rd(addr));
         chk("R9 per-cycle irq", DW'(irq), DW'(|(raw_m & en_m)));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      @(negedge clk);
      addr = a;
      #1;
      chk(tag, rdata, exp);
   endtask

   task automatic set_pin(input int i, input logic v);
      pins[i] = v;
      touch();
   endtask

   task automatic pulse(input int i);
      @(negedge clk);
      #1 set_pin(i, 1'b1);
      #2 set_pin(i, 1'b0);
   endtask

   initial begin
      pipe.push_back('0);
      idle(3);
      rst_n = 1'b1;

      // R1: reset state
      rd_chk("R1 enable", 5'h00, 0);
      rd_chk("R1 raw", 5'h04, 0);
      rd_chk("R1 masked", 5'h08, 0);
      rd_chk("R1 polarity", 5'h10, 0);
      rd_chk("R1 spare", 5'h14, 0);
      chk("R1 irq", DW'(irq), 0);

      // R2: storage and width of writable registers
      wr_reg(5'h14, 32'hFFFF_FF5A);
      rd_chk("R2 spare readback", 5'h14, 32'h5A);
      wr_reg(5'h10, 32'h0000_0180);
      rd_chk("R2 polarity readback", 5'h10, 32'h80);
      wr_reg(5'h10, 32'h0);
      wr_reg(5'h00, 32'hFFFF_FF00);
      rd_chk("R2 enable upper ignored", 5'h00, 0);

      // R3: polarity selects the active level
      wr_reg(5'h10, 32'h02);
      wr_reg(5'h00, 32'h03);
      idle(4);
      rd_chk("R3 low-active ch1", 5'h04, 32'h02);
      set_pin(0, 1'b1);
      idle(4);
      rd_chk("R3 high-active ch0", 5'h04, 32'h03);
      rd_chk("R3 masked", 5'h08, 32'h03);
      chk("R3 irq", DW'(irq), 1);

      // R8: clear while still active keeps capture
      wr_reg(5'h0C, 32'h03);
      idle(4);
      rd_chk("R8 clear while active", 5'h04, 32'h03);

      // R7: clear once inactive, zero bits untouched
      set_pin(0, 1'b0);
      wr_reg(5'h0C, 32'h01);
      idle(4);
      rd_chk("R7 clear ch0 only", 5'h04, 32'h02);
      wr_reg(5'h10, 32'h00);
      wr_reg(5'h0C, 32'h02);
      idle(4);
      rd_chk("R7 clear ch1", 5'h04, 32'h00);
      chk("R7 irq dropped", DW'(irq), 0);

      // R4: disabled channel does not capture
      pulse(4);
      set_pin(5, 1'b1);
      idle(4);
      rd_chk("R4 disabled no capture", 5'h04, 32'h00);
      set_pin(5, 1'b0);

      // R5: pulse entirely between clock edges
      wr_reg(5'h00, 32'h10);
      pulse(4);
      idle(4);
      rd_chk("R5 short pulse captured", 5'h04, 32'h10);
      chk("R5 irq", DW'(irq), 1);

      // R6: two-edge latency
      wr_reg(5'h00, 32'h14);
      @(negedge clk);
      addr = 5'h04;
      #1 set_pin(2, 1'b1);
      @(negedge clk);
      #1 chk("R6 not after one edge", rdata, 32'h10);
      @(negedge clk);
      #1 chk("R6 visible after two edges", rdata, 32'h14);
      set_pin(2, 1'b0);

      // R9: masking hides without discarding
      wr_reg(5'h00, 32'h04);
      rd_chk("R9 masked", 5'h08, 32'h04);
      rd_chk("R9 raw kept", 5'h04, 32'h14);
      chk("R9 irq on", DW'(irq), 1);
      wr_reg(5'h00, 32'h00);
      rd_chk("R9 masked none", 5'h08, 32'h00);
      chk("R9 irq off", DW'(irq), 0);
      rd_chk("R9 raw still kept", 5'h04, 32'h14);

      // R10: clear offset and unlisted offsets
      rd_chk("R10 clear reads zero", 5'h0C, 0);
      wr_reg(5'h18, 32'hFF);
      rd_chk("R10 unlisted reads zero", 5'h18, 0);
      rd_chk("R10 unlisted 0x1C", 5'h1C, 0);
      rd_chk("R10 spare untouched", 5'h14, 32'h5A);
      rd_chk("R10 enable untouched", 5'h00, 0);
      rd_chk("R10 polarity untouched", 5'h10, 0);

      // R11: spare bits do not alter behaviour
      wr_reg(5'h14, 32'hFF);
      wr_reg(5'h0C, 32'h14);
      idle(4);
      rd_chk("R11 clear with spare set", 5'h04, 0);
      wr_reg(5'h00, 32'h01);
      set_pin(0, 1'b1);
      idle(4);
      rd_chk("R11 capture with spare set", 5'h04, 32'h01);
      chk("R11 irq", DW'(irq), 1);
      rd_chk("R11 spare value", 5'h14, 32'hFF);

      // R1: reset while captured and input active
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(3);
      rd_chk("R1 raw after reset", 5'h04, 0);
      rd_chk("R1 enable after reset", 5'h00, 0);
      rd_chk("R1 spare after reset", 5'h14, 0);
      chk("R1 irq after reset", DW'(irq), 0);
      set_pin(0, 1'b0);
      idle(2);

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule